// File: doc/BRIEF.md
# Row-Miss-Driven Promotion Filter

This unit sits beside the request path of the slow, dense tier in a two-tier memory controller. For each access it accepts a bank index and a row address. It decides whether that access finds the same row already open in that bank or forces a new row to be opened. It keeps a small set-associative table of recently missed rows, and each row in the table has a saturating count of how often it has missed the open row.

When a row's miss count reaches a programmed limit, the unit asks for that row to be copied into the fast tier. A row that keeps hitting its open row never climbs toward that limit, so it stays where it is. An interval timer drops every entry in the table from time to time, so only rows that have been reused recently get promoted.

The migration request carries one row address and uses a valid/ready handshake. Moving the data, the fast-tier cache and any tuning of the limit belong to other blocks.

Top module: `rbl_promote_unit`

## Requirements
- R1: Each bank remembers the row of its last accepted access. An access is a hit (`rsp_hit`=1) only when its row equals the remembered row of the same bank. Otherwise it is a miss, and its row becomes that bank's open row. After reset no bank has an open row, and an access to one bank never changes another bank's state.
- R2: An accepted request (`req_valid` and `req_ready` both high at a clock edge) gives one response. `rsp_valid` is low after that first edge and high for one cycle after the second edge. `req_ready` stays low while a request is in flight.
- R3: The table is keyed by `req_row` alone; the bank does not take part. On a miss, a row not in the table is entered with count 1, and a row already in the table has its count raised by one. `rsp_count` on a miss is the count after this update.
- R4: On a hit, `rsp_count` is the row's count in the table, or 0 when the row is absent, and the table is left unchanged.
- R5: A count never goes above 2^CNT_W-1. A miss at that value leaves it there.
- R6: A miss whose updated count is greater than or equal to `cfg_threshold` raises `mig_valid` in the same cycle as its response, with `mig_row` equal to the request row. The row's entry is dropped, so its next miss counts from 1. A hit never raises `mig_valid`. A threshold above 2^CNT_W-1 disables promotion.
- R7: Once raised, `mig_valid` stays high and `mig_row` stays unchanged until a clock edge with `mig_ready` high. No request is accepted while `mig_valid` is high.
- R8: The set of a row is `req_row[log2(SETS)-1:0]`. Rows in different sets never displace each other. A miss on an absent row fills the lowest free way of its set. When the set is full, it replaces the way whose row missed least recently; hits do not change that order.
- R9: While `cfg_interval` is non-zero, `cfg_interval` cycles of idle time start a clear of the whole table. The clear takes SETS cycles, with `req_ready` low. The same clear runs right after reset. A zero `cfg_interval` disables the timer. The open-row state of the banks is kept through a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can accept an access |
| req_bank | input | log2(NUM_BANKS) | Bank of the access |
| req_row | input | ROW_W | Row address of the access |
| cfg_threshold | input | CNT_W+1 | Miss count that triggers promotion |
| cfg_interval | input | INT_W | Idle cycles between table clears, 0 disables |
| rsp_valid | output | 1 | Response for the last accepted access |
| rsp_hit | output | 1 | Access found its row open |
| rsp_count | output | CNT_W | Miss count of the row after the access |
| mig_valid | output | 1 | Promotion request pending |
| mig_ready | input | 1 | Promotion request taken |
| mig_row | output | ROW_W | Row to promote |

## Verification
Directed runs use a small configuration: four banks, four sets of two ways and three-bit counters. One run repeats a single row, which separates hits from misses. Another alternates two rows in one bank, which makes both counts climb and finally separates saturation from promotion. Three rows sharing a set show that the least recently missed row is the one evicted. A long pseudo-random stream over twelve rows and four banks, run at several thresholds, is compared access by access with an arithmetic model in the bench. A clear triggered by the timer shows that counts drop to zero while the open rows survive.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
  typedef enum logic [1:0] {
    SW_IDLE,
    SW_WAIT,
    SW_RUN
  } sweep_st_e;
endpackage

// File: rtl/rbl_open_rows.sv
// Per-bank open-row tracker with a registered hit flag.
module rbl_open_rows #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_en,
  input  logic [$clog2(NUM_BANKS)-1:0] acc_bank,
  input  logic [ROW_W-1:0]             acc_row,
  output logic                         hit_q
);
  logic [ROW_W-1:0]     open_row [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= '0;
      hit_q    <= 1'b0;
    end else if (acc_en) begin
      hit_q              <= open_vld[acc_bank] && (open_row[acc_bank] == acc_row);
      open_vld[acc_bank] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) open_row[acc_bank] <= acc_row;
  end
endmodule

// File: rtl/rbl_way_ram.sv
// One way of the count table: simple dual-port memory with a registered read.
module rbl_way_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rbl_interval_sweep.sv
// Interval timer and set-by-set clear sequencer.
module rbl_interval_sweep
  import rbl_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int INT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W-1:0]        interval,
  input  logic                    pipe_idle,
  output logic                    busy,
  output logic                    sw_we,
  output logic [$clog2(SETS)-1:0] sw_idx
);
  localparam int IDX_W = $clog2(SETS);

  sweep_st_e        st;
  logic [INT_W-1:0] tick;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SW_RUN;
      idx  <= '0;
      tick <= '0;
    end else begin
      case (st)
        SW_IDLE: begin
          tick <= tick + 1'b1;
          if ((interval != '0) && (tick >= interval - 1'b1)) begin
            st   <= SW_WAIT;
            tick <= '0;
          end
        end
        SW_WAIT: begin
          if (pipe_idle) begin
            st  <= SW_RUN;
            idx <= '0;
          end
        end
        SW_RUN: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(SETS - 1)) st <= SW_IDLE;
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  assign busy   = (st != SW_IDLE);
  assign sw_we  = (st == SW_RUN);
  assign sw_idx = idx;
endmodule

// File: rtl/rbl_promote_unit.sv
// Row-miss-driven promotion filter (top).
module rbl_promote_unit #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 20,
  parameter int SETS      = 128,
  parameter int WAYS      = 16,
  parameter int CNT_W     = 6,
  parameter int INT_W     = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [CNT_W:0]               cfg_threshold,
  input  logic [INT_W-1:0]             cfg_interval,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [CNT_W-1:0]             rsp_count,
  output logic                         mig_valid,
  input  logic                         mig_ready,
  output logic [ROW_W-1:0]             mig_row
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ROW_W - IDX_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam int ENT_W = 1 + TAG_W + CNT_W + AGE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(WAYS - 1);

  logic             accept;
  logic             sw_busy, sw_we;
  logic [IDX_W-1:0] sw_idx;
  logic             s1_valid;
  logic [ROW_W-1:0] s1_row;
  logic             s1_hit;
  logic [IDX_W-1:0] s1_idx;
  logic [TAG_W-1:0] s1_tag;

  logic [ENT_W-1:0] rd_ent [WAYS];
  logic [ENT_W-1:0] wr_ent [WAYS];
  logic             tbl_we;
  logic [IDX_W-1:0] wr_idx;

  logic             e_vld [WAYS];
  logic [TAG_W-1:0] e_tag [WAYS];
  logic [CNT_W-1:0] e_cnt [WAYS];
  logic [AGE_W-1:0] e_age [WAYS];

  logic             hit_any, free_any, promote;
  logic [AGE_W-1:0] hit_way, free_way, old_way, tgt_way, tgt_age;
  logic [CNT_W-1:0] cur_cnt, new_cnt;

  assign req_ready = !s1_valid && !mig_valid && !sw_busy;
  assign accept    = req_valid && req_ready;
  assign s1_idx    = s1_row[IDX_W-1:0];
  assign s1_tag    = s1_row[ROW_W-1:IDX_W];

  rbl_open_rows #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
  ) u_open (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (accept),
    .acc_bank(req_bank),
    .acc_row (req_row),
    .hit_q   (s1_hit)
  );

  rbl_interval_sweep #(
    .SETS (SETS),
    .INT_W(INT_W)
  ) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .interval (cfg_interval),
    .pipe_idle(!s1_valid),
    .busy     (sw_busy),
    .sw_we    (sw_we),
    .sw_idx   (sw_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= accept;
    if (accept) s1_row <= req_row;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    rbl_way_ram #(
      .DEPTH(SETS),
      .WIDTH(ENT_W)
    ) u_ram (
      .clk  (clk),
      .we   (tbl_we),
      .waddr(wr_idx),
      .wdata(wr_ent[w]),
      .raddr(req_row[IDX_W-1:0]),
      .rdata(rd_ent[w])
    );
    assign e_vld[w] = rd_ent[w][ENT_W-1];
    assign e_tag[w] = rd_ent[w][ENT_W-2 -: TAG_W];
    assign e_cnt[w] = rd_ent[w][AGE_W+CNT_W-1 -: CNT_W];
    assign e_age[w] = rd_ent[w][AGE_W-1:0];
  end

  // Lookup, victim choice and count update for the request in stage 1.
  always_comb begin
    hit_any  = 1'b0;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    old_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_any && e_vld[w] && (e_tag[w] == s1_tag)) begin
        hit_any = 1'b1;
        hit_way = AGE_W'(w);
      end
      if (!free_any && !e_vld[w]) begin
        free_any = 1'b1;
        free_way = AGE_W'(w);
      end
      if (e_age[w] == AGE_OLD) old_way = AGE_W'(w);
    end
    cur_cnt = hit_any ? e_cnt[hit_way] : '0;
    if (!hit_any)               new_cnt = CNT_W'(1);
    else if (cur_cnt == CNT_MAX) new_cnt = CNT_MAX;
    else                        new_cnt = cur_cnt + 1'b1;
    tgt_way = hit_any ? hit_way : (free_any ? free_way : old_way);
    tgt_age = e_age[tgt_way];
    promote = ({1'b0, new_cnt} >= cfg_threshold);
  end

  always_comb begin
    tbl_we = sw_we || (s1_valid && !s1_hit);
    wr_idx = sw_we ? sw_idx : s1_idx;
    for (int w = 0; w < WAYS; w++) begin
      if (sw_we) begin
        wr_ent[w] = {1'b0, {TAG_W{1'b0}}, {CNT_W{1'b0}}, AGE_W'(w)};
      end else if (AGE_W'(w) == tgt_way) begin
        wr_ent[w] = {!promote, s1_tag, new_cnt, {AGE_W{1'b0}}};
      end else begin
        wr_ent[w] = {e_vld[w], e_tag[w], e_cnt[w],
                     (e_age[w] < tgt_age) ? e_age[w] + 1'b1 : e_age[w]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_count <= '0;
      mig_valid <= 1'b0;
      mig_row   <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_hit   <= s1_hit;
        rsp_count <= s1_hit ? cur_cnt : new_cnt;
      end
      if (mig_valid && mig_ready) mig_valid <= 1'b0;
      if (s1_valid && !s1_hit && promote) begin
        mig_valid <= 1'b1;
        mig_row   <= s1_row;
      end
    end
  end
endmodule

// File: rtl/rbl_promote_checker.sv
module rbl_promote_checker #(
  parameter int ROW_W = 20,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] rsp_count,
  input logic [CNT_W:0]   cfg_threshold,
  input logic             mig_valid,
  input logic             mig_ready,
  input logic [ROW_W-1:0] mig_row
);
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !rsp_valid ##1 rsp_valid);

  p_busy_in_flight_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_miss_count_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_count != '0));

  p_promote_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mig_valid) |-> (rsp_valid && !rsp_hit &&
                          ({1'b0, rsp_count} >= $past(cfg_threshold))));

  p_mig_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_row)));

  p_mig_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> !req_ready);
endmodule

bind rbl_promote_unit rbl_promote_checker #(
  .ROW_W(ROW_W),
  .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/rbl_promote_unit_bench.sv
module rbl_promote_unit_bench;
  localparam int NB = 4, RW = 8, NS = 4, NW = 2, CW = 3, IW = 8;
  localparam int CMAX = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW:0]   cfg_threshold = 4'd8;
  logic [IW-1:0] cfg_interval = '0;
  logic          rsp_valid, rsp_hit;
  logic [CW-1:0] rsp_count;
  logic          mig_valid;
  logic          mig_ready = 1'b0;
  logic [RW-1:0] mig_row;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rbl_promote_unit #(
    .NUM_BANKS(NB), .ROW_W(RW), .SETS(NS), .WAYS(NW), .CNT_W(CW), .INT_W(IW)
  ) u_rbl_promote_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .cfg_threshold(cfg_threshold),
    .cfg_interval(cfg_interval), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_count(rsp_count), .mig_valid(mig_valid), .mig_ready(mig_ready),
    .mig_row(mig_row)
  );

  // Reference model state
  int m_open [NB];
  bit m_openv [NB];
  bit tv [NS][NW];
  int tr [NS][NW];
  int tc [NS][NW];
  int ts [NS][NW];
  int stamp = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) tv[s][w] = 0;
  endtask

  task automatic model(input int b, input int r, output bit eh, output int ec, output bit em);
    int s = r % NS;
    int m = -1;
    int v = -1;
    eh = m_openv[b] && (m_open[b] == r);
    m_openv[b] = 1;
    m_open[b] = r;
    em = 0;
    for (int w = 0; w < NW; w++) if (tv[s][w] && tr[s][w] == r) m = w;
    if (eh) begin
      ec = (m >= 0) ? tc[s][m] : 0;
    end else begin
      if (m >= 0) begin
        v = m;
        tc[s][v] = (tc[s][v] >= CMAX) ? CMAX : tc[s][v] + 1;
      end else begin
        for (int w = 0; w < NW; w++) if (!tv[s][w] && v < 0) v = w;
        if (v < 0) begin
          v = 0;
          for (int w = 1; w < NW; w++) if (ts[s][w] < ts[s][v]) v = w;
        end
        tv[s][v] = 1;
        tr[s][v] = r;
        tc[s][v] = 1;
      end
      stamp++;
      ts[s][v] = stamp;
      ec = tc[s][v];
      if (ec >= int'(cfg_threshold)) begin
        em = 1;
        tv[s][v] = 0;
      end
    end
  endtask

  task automatic serve_mig(input int r);
    chk("R7", req_ready, 0, "ready while promotion pending");
    repeat (3) @(negedge clk);
    chk("R7", mig_valid, 1, "promotion held");
    chk("R7", mig_row, r, "promotion row held");
    mig_ready = 1'b1;
    @(negedge clk);
    mig_ready = 1'b0;
    chk("R7", mig_valid, 0, "promotion dropped after accept");
  endtask

  task automatic do_req(input int b, input int r, output int got);
    bit eh;
    int ec;
    bit em;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_bank = 2'(b);
    req_row = RW'(r);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", req_ready, 0, "ready with request in flight");
    chk("R2", rsp_valid, 0, "response too early");
    @(negedge clk);
    model(b, r, eh, ec, em);
    chk("R2", rsp_valid, 1, "response valid");
    chk("R1", rsp_hit, eh, "hit flag");
    chk(eh ? "R4" : "R3", rsp_count, ec, "count");
    chk("R6", mig_valid, em, "promotion raised");
    got = rsp_count;
    if (mig_valid) begin
      chk("R6", mig_row, r, "promotion row");
      serve_mig(r);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int got;
    int lfsr = 16'hACE1;
    int pb = 0, pr = 0;
    for (int b = 0; b < NB; b++) begin m_openv[b] = 0; m_open[b] = 0; end
    model_clear();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk("R9", req_ready, 0, "clear after reset blocks requests");
    chk("R2", rsp_valid, 0, "no response after reset");
    chk("R6", mig_valid, 0, "no promotion after reset");

    // Repeating one row: first miss, then hits (R1, R4)
    cfg_threshold = 4'd8;
    do_req(0, 1, got); chk("R1", got, 1, "first access counts");
    do_req(0, 1, got); chk("R4", got, 1, "hit leaves count");
    do_req(1, 1, got); chk("R3", got, 2, "same row other bank is a miss");
    // Alternating two rows in one bank until saturation (R5)
    for (int i = 0; i < 8; i++) begin
      do_req(0, 5, got);
      do_req(0, 1, got);
    end
    chk("R5", got, CMAX, "count saturates");

    // Eviction in a full set: rows 2, 6, 10 share set 2 (R8)
    do_req(1, 2, got);
    do_req(1, 6, got);
    do_req(1, 2, got); chk("R8", got, 2, "resident row keeps count");
    do_req(1, 10, got); chk("R8", got, 1, "new row allocated");
    do_req(1, 6, got); chk("R8", got, 1, "least recently missed row was evicted");
    do_req(1, 3, got); chk("R8", got, 1, "other set untouched");

    // Promotion at threshold 3 (R6)
    cfg_threshold = 4'd3;
    do_req(2, 7, got);
    do_req(2, 11, got);
    do_req(2, 7, got);
    do_req(2, 11, got);
    do_req(2, 7, got);  chk("R6", got, 3, "promoting count");
    do_req(2, 7, got);  chk("R4", got, 0, "hit after promotion sees no entry");
    do_req(2, 11, got); chk("R6", got, 3, "second row promotes");
    do_req(2, 7, got);  chk("R6", got, 1, "promoted row restarts at one");

    // Threshold one: every miss promotes
    cfg_threshold = 4'd1;
    do_req(3, 9, got);
    do_req(3, 13, got);

    // Timed clear keeps open rows (R9)
    cfg_threshold = 4'd8;
    do_req(0, 4, got);
    do_req(0, 0, got);
    do_req(0, 4, got); chk("R9", got, 2, "count before clear");
    cfg_interval = 8'd20;
    repeat (80) @(negedge clk);
    cfg_interval = 8'd0;
    while (!req_ready) @(negedge clk);
    model_clear();
    do_req(0, 4, got); chk("R9", got, 0, "cleared count seen on open-row hit");
    do_req(0, 0, got); chk("R9", got, 1, "cleared row restarts at one");

    // Pseudo-random stream at several thresholds
    for (int ph = 0; ph < 3; ph++) begin
      cfg_threshold = (ph == 0) ? 4'd4 : (ph == 1) ? 4'd8 : 4'd2;
      for (int i = 0; i < 200; i++) begin
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
        if ((lfsr & 7) < 3) begin
          do_req(pb, pr, got);
        end else begin
          pb = (lfsr >> 3) % NB;
          pr = (lfsr >> 5) % 12;
          do_req(pb, pr, got);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule